// File: doc/BRIEF.md
# Page-Mode DRAM Burst Read Controller

This controller fetches 32-byte cache blocks from an asynchronous DRAM array of 2048 rows by 2048 columns. The array has one 11-bit address bus that carries the row and the column in turn. Each accepted request opens a single row with a row strobe. It then reads four 64-bit words from that row under a column strobe, one column address per word. The words come back in wrap-around order, starting at the word the request names inside its four-word block.

Three beat-timing profiles are available, and the profile is chosen with each request:

- Fast page (5-3-3-3) gives each word a single-cycle pulse.
- Extended data out (5-2-2-2) keeps each of the first three words on the output while the next column is presented.
- Synchronous (4-1-1-1) delivers one word per cycle after the first.

When a burst completes, the block reports how many memory cycles it used. A built-in scheduler raises one refresh request every `REF_INTERVAL` cycles. The default of 195 cycles at 50 MHz covers all 2048 rows within 8 ms. Each refresh is a row-strobe-only cycle on the next row, and the row counter wraps after the last row. A refresh is never inserted into a burst. It runs in the idle gap before the next request is accepted.

Top module: `pgd_burst_ctrl`

## Requirements
- R1: After acceptance, the first cycle drives the row on `dram_addr` with `dram_ras` high and `dram_cas` low. From then until the burst ends `dram_ras` stays high, and `dram_cas` is only ever high while `dram_ras` is high. From the second cycle on, `dram_addr` carries a column with `dram_cas` high.
- R2: A burst delivers four 64-bit words with `beat_idx` = 0, 1, 2, 3. Word k is the array word at the requested row and column {req_col[10:2], (req_col[1:0]+k) mod 4}.
- R3: With profile code 0 (fast page), word k appears on `beat_valid` for exactly one cycle, registered at clock edge 5+3k after the acceptance edge.
- R4: With profile code 1 (extended data out), word k is registered at edge 5+2k after the acceptance edge. Words 0 to 2 stay valid and unchanged for two cycles, until the next word replaces them. Word 3 stays valid for one cycle.
- R5: With profile code 2 or 3 (synchronous), word k is registered at edge 4+k after the acceptance edge and is valid for one cycle.
- R6: `done` pulses together with word 3. `done_cycles` then holds the burst length counted from the acceptance edge: 14, 11 or 7 for the three profiles.
- R7: `req_profile` is sampled only at the acceptance edge. Changing it during a burst leaves that burst's timing unchanged.
- R8: `req_ready` is low during a burst, during a refresh, and while a refresh is pending.
- R9: Every `REF_INTERVAL` cycles a refresh is requested. A refresh drives the next row on `dram_addr` with `dram_ras` high for `REF_RAS_CYC` cycles and `dram_cas` low. Refresh rows ascend from 0 and wrap from 2047 back to 0.
- R10: A pending refresh never starts inside a burst. It is taken at the first idle cycle, ahead of any waiting request, so it waits at most one full burst plus two cycles.
- R11: During reset `dram_ras`, `dram_cas`, `beat_valid` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, one memory cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Block read request |
| req_row | input | ADDR_W | Row of the requested block |
| req_col | input | ADDR_W | Column; upper bits select the block, lower two bits select the first word |
| req_profile | input | 2 | Timing profile: 0 fast page, 1 extended data out, 2/3 synchronous |
| req_ready | output | 1 | Request is accepted at the next edge when high together with req_valid |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_ras | output | 1 | Row strobe, active high |
| dram_cas | output | 1 | Column strobe, active high |
| dram_rdata | input | DATA_W | Read data from the array |
| beat_valid | output | 1 | Output word valid |
| beat_idx | output | BEAT_W | Position of the word within the burst |
| beat_data | output | DATA_W | Output word |
| done | output | 1 | Burst finished (with the last word) |
| done_cycles | output | CNT_W | Memory cycles used by the finished burst |

## Verification
Every output is registered. A word captured at edge F+kG after the acceptance edge can therefore be seen in the half cycle that follows that edge. F and G are 5/3, 5/2 or 4/1 depending on the profile. `done` and `done_cycles` are due at the same edge as word 3. The row address is seen in the half cycle after the acceptance edge, and the first column address one cycle later.

The bench samples at each falling edge and counts edges from the acceptance edge. It then compares the outputs against the schedule its own functions compute from the profile captured at that edge, whatever value `req_profile` takes afterwards. Refresh is checked by a separate falling-edge monitor on the strobes. It checks each row-strobe-only pulse for row order, pulse length, spacing against `REF_INTERVAL`, and overlap with a burst.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

  typedef enum logic [1:0] {
    PROF_FPM  = 2'd0,
    PROF_EDO  = 2'd1,
    PROF_SYNC = 2'd2,
    PROF_SYNB = 2'd3
  } prof_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BURST   = 2'd1,
    ST_REFRESH = 2'd2
  } state_e;

  // cycles from acceptance edge to the first captured word
  function automatic int unsigned first_lat(prof_e p);
    case (p)
      PROF_FPM: return 5;
      PROF_EDO: return 5;
      default:  return 4;
    endcase
  endfunction

  // cycles between later words
  function automatic int unsigned beat_gap(prof_e p);
    case (p)
      PROF_FPM: return 3;
      PROF_EDO: return 2;
      default:  return 1;
    endcase
  endfunction

  function automatic int unsigned burst_len(prof_e p, int unsigned beats);
    return first_lat(p) + beat_gap(p) * (beats - 1);
  endfunction

endpackage

// File: rtl/pgd_refresh_sched.sv
module pgd_refresh_sched #(
  parameter int INTERVAL = 195,
  parameter int ROW_W    = 11,
  localparam int TMR_W   = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  output logic             pend,
  output logic [ROW_W-1:0] row
);

  logic [TMR_W-1:0] tmr;
  logic             tick;

  assign tick = (tmr == TMR_W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr  <= '0;
      pend <= 1'b0;
      row  <= '0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (take) begin
        pend <= 1'b0;
        row  <= row + 1'b1;
      end
      if (tick) pend <= 1'b1;
    end
  end

endmodule

// File: rtl/pgd_beat_timer.sv
module pgd_beat_timer
  import pgd_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int CNT_W = 4,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  prof_e             req_prof,
  output prof_e             prof_q,
  output logic [CNT_W-1:0]  cnt,
  output logic [BEAT_W-1:0] k,
  output logic              capture,
  output logic              last
);

  logic             active;
  logic [CNT_W-1:0] nxt_cap;

  assign capture = active && (cnt == nxt_cap);
  assign last    = capture && (k == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      nxt_cap <= '0;
      k       <= '0;
      prof_q  <= PROF_FPM;
    end else if (start) begin
      active  <= 1'b1;
      cnt     <= CNT_W'(1);
      k       <= '0;
      nxt_cap <= CNT_W'(first_lat(req_prof));
      prof_q  <= req_prof;
    end else if (active) begin
      cnt <= cnt + 1'b1;
      if (capture) begin
        k       <= k + 1'b1;
        nxt_cap <= nxt_cap + CNT_W'(beat_gap(prof_q));
        if (last) active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pgd_burst_ctrl.sv
module pgd_burst_ctrl
  import pgd_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 64,
  parameter int BEATS        = 4,
  parameter int REF_INTERVAL = 195,
  parameter int REF_RAS_CYC  = 3,
  localparam int BEAT_W      = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int MAX_TOTAL   = 5 + 3 * (BEATS - 1),
  localparam int CNT_W       = $clog2(MAX_TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [ADDR_W-1:0] req_col,
  input  logic [1:0]        req_profile,
  output logic              req_ready,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              dram_ras,
  output logic              dram_cas,
  input  logic [DATA_W-1:0] dram_rdata,
  output logic              beat_valid,
  output logic [BEAT_W-1:0] beat_idx,
  output logic [DATA_W-1:0] beat_data,
  output logic              done,
  output logic [CNT_W-1:0]  done_cycles
);

  localparam int RC_W = $clog2(REF_RAS_CYC + 1);

  state_e              state;
  logic                ref_pend;
  logic [ADDR_W-1:0]   ref_row;
  logic                ref_take;
  logic                tm_start;
  prof_e               prof_q;
  logic [CNT_W-1:0]    tm_cnt;
  logic [BEAT_W-1:0]   tm_k;
  logic                tm_capture;
  logic                tm_last;
  logic [ADDR_W-BEAT_W-1:0] col_blk;
  logic [BEAT_W-1:0]   col_lo;
  logic [RC_W-1:0]     rcnt;

  assign req_ready = (state == ST_IDLE) && !ref_pend;
  assign ref_take  = (state == ST_IDLE) && ref_pend;
  assign tm_start  = req_ready && req_valid;

  pgd_refresh_sched #(
    .INTERVAL (REF_INTERVAL),
    .ROW_W    (ADDR_W)
  ) u_refresh (
    .clk  (clk),
    .rst  (rst),
    .take (ref_take),
    .pend (ref_pend),
    .row  (ref_row)
  );

  pgd_beat_timer #(
    .BEATS (BEATS),
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (tm_start),
    .req_prof (prof_e'(req_profile)),
    .prof_q   (prof_q),
    .cnt      (tm_cnt),
    .k        (tm_k),
    .capture  (tm_capture),
    .last     (tm_last)
  );

  // strobe / address sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      dram_addr   <= '0;
      dram_ras    <= 1'b0;
      dram_cas    <= 1'b0;
      col_blk     <= '0;
      col_lo      <= '0;
      rcnt        <= '0;
      done        <= 1'b0;
      done_cycles <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            state     <= ST_REFRESH;
            dram_addr <= ref_row;
            dram_ras  <= 1'b1;
            dram_cas  <= 1'b0;
            rcnt      <= '0;
          end else if (req_valid) begin
            state     <= ST_BURST;
            dram_addr <= req_row;
            dram_ras  <= 1'b1;
            dram_cas  <= 1'b0;
            col_blk   <= req_col[ADDR_W-1:BEAT_W];
            col_lo    <= req_col[BEAT_W-1:0];
          end
        end
        ST_REFRESH: begin
          rcnt <= rcnt + 1'b1;
          if (rcnt == RC_W'(REF_RAS_CYC - 1)) begin
            dram_ras <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        ST_BURST: begin
          if (tm_cnt == CNT_W'(1)) begin
            dram_cas  <= 1'b1;
            dram_addr <= {col_blk, col_lo};
          end
          if (tm_capture) begin
            if (tm_last) begin
              dram_ras    <= 1'b0;
              dram_cas    <= 1'b0;
              state       <= ST_IDLE;
              done        <= 1'b1;
              done_cycles <= tm_cnt;
            end else begin
              dram_addr <= {col_blk, BEAT_W'(col_lo + tm_k + 1'b1)};
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // output word register; extended-data-out keeps a word until replaced
  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      beat_idx   <= '0;
      beat_data  <= '0;
    end else if (tm_capture) begin
      beat_valid <= 1'b1;
      beat_idx   <= tm_k;
      beat_data  <= dram_rdata;
    end else if (!(state == ST_BURST && prof_q == PROF_EDO)) begin
      beat_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pgd_burst_ctrl_chk.sv
module pgd_burst_ctrl_chk
  import pgd_pkg::*;
#(
  parameter int BEATS     = 4,
  parameter int BEAT_W    = 2,
  parameter int DATA_W    = 64,
  parameter int CNT_W     = 4,
  parameter int MAX_TOTAL = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              dram_ras,
  input logic              dram_cas,
  input logic              beat_valid,
  input logic [BEAT_W-1:0] beat_idx,
  input logic [DATA_W-1:0] beat_data,
  input logic              done,
  input logic [CNT_W-1:0]  done_cycles,
  input prof_e             prof_q,
  input logic              ref_pend
);

  logic [7:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst)           wait_cnt <= '0;
    else if (ref_pend) wait_cnt <= wait_cnt + 1'b1;
    else               wait_cnt <= '0;
  end

  p_cas_under_ras_r1: assert property (@(posedge clk) disable iff (rst)
    dram_cas |-> dram_ras);

  p_row_before_col_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras) |-> !dram_cas);

  p_held_word_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && $past(beat_valid) && beat_idx == $past(beat_idx)) |-> $stable(beat_data));

  p_done_last_word_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (beat_valid && beat_idx == BEAT_W'(BEATS - 1)));

  p_done_length_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_cycles == CNT_W'(burst_len(prof_q, BEATS))));

  p_not_ready_busy_r8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !dram_ras);

  p_refresh_wait_r10: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= 8'(MAX_TOTAL + 2));

  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dram_ras && !dram_cas && !beat_valid && !done));

endmodule

bind pgd_burst_ctrl pgd_burst_ctrl_chk #(
  .BEATS     (BEATS),
  .BEAT_W    (BEAT_W),
  .DATA_W    (DATA_W),
  .CNT_W     (CNT_W),
  .MAX_TOTAL (MAX_TOTAL)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .dram_ras    (dram_ras),
  .dram_cas    (dram_cas),
  .beat_valid  (beat_valid),
  .beat_idx    (beat_idx),
  .beat_data   (beat_data),
  .done        (done),
  .done_cycles (done_cycles),
  .prof_q      (prof_q),
  .ref_pend    (ref_pend)
);

// File: tb/test_pgd_burst_ctrl.sv
module test_pgd_burst_ctrl;

  localparam int AW   = 11;
  localparam int DW   = 64;
  localparam int RINT = 40;
  localparam int RRAS = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_row = '0;
  logic [AW-1:0] req_col = '0;
  logic [1:0]    req_profile = 2'd0;
  logic          req_ready;
  logic [AW-1:0] dram_addr;
  logic          dram_ras;
  logic          dram_cas;
  logic [DW-1:0] dram_rdata;
  logic          beat_valid;
  logic [1:0]    beat_idx;
  logic [DW-1:0] beat_data;
  logic          done;
  logic [3:0]    done_cycles;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit in_burst = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pgd_burst_ctrl #(
    .ADDR_W (AW), .DATA_W (DW), .BEATS (4),
    .REF_INTERVAL (RINT), .REF_RAS_CYC (RRAS)
  ) i_pgd_burst_ctrl (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_row (req_row), .req_col (req_col),
    .req_profile (req_profile), .req_ready (req_ready),
    .dram_addr (dram_addr), .dram_ras (dram_ras), .dram_cas (dram_cas),
    .dram_rdata (dram_rdata),
    .beat_valid (beat_valid), .beat_idx (beat_idx), .beat_data (beat_data),
    .done (done), .done_cycles (done_cycles)
  );

  // behavioural array: word content derived from its coordinates
  function automatic logic [DW-1:0] word_at(logic [AW-1:0] r, logic [AW-1:0] c);
    return {16'h5a3c, r, c, ~c, r ^ c, 4'h9};
  endfunction

  logic [AW-1:0] m_row = '0;
  logic          m_ras_d = 1'b0;
  always @(posedge clk) begin
    if (dram_ras && !m_ras_d) m_row <= dram_addr;
    m_ras_d <= dram_ras;
  end
  assign dram_rdata = dram_cas ? word_at(m_row, dram_addr) : '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int f_of(logic [1:0] p);
    return (p == 2'd0 || p == 2'd1) ? 5 : 4;
  endfunction
  function automatic int g_of(logic [1:0] p);
    return (p == 2'd0) ? 3 : (p == 2'd1) ? 2 : 1;
  endfunction
  function automatic string ptag(logic [1:0] p);
    return (p == 2'd0) ? "R3" : (p == 2'd1) ? "R4" : "R5";
  endfunction

  task automatic run_burst(input logic [AW-1:0] row, input logic [AW-1:0] col,
                           input logic [1:0] prof, input bit flip);
    int f, g, tot;
    string tt;
    f   = f_of(prof);
    g   = g_of(prof);
    tot = f + 3 * g;
    tt  = flip ? "R7" : ptag(prof);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_row = row; req_col = col; req_profile = prof;
    @(negedge clk);
    req_valid = 1'b0;
    in_burst  = 1'b1;
    if (flip) req_profile = (prof == 2'd0) ? 2'd2 : 2'd0;
    chk(dram_ras && !dram_cas, "R1 row strobe", {dram_ras, dram_cas}, 2'b10);
    chk(dram_addr == row, "R1 row addr", dram_addr, row);
    chk(!req_ready, "R8 busy", req_ready, 0);
    for (int j = 1; j <= tot; j++) begin
      bit ev;
      int ek;
      @(negedge clk);
      if (j == 1) begin
        chk(dram_cas && dram_ras, "R1 col strobe", {dram_ras, dram_cas}, 2'b11);
        chk(dram_addr == col, "R1 col addr", dram_addr, col);
      end
      ev = 1'b0; ek = 0;
      for (int k = 0; k < 4; k++) begin
        if (j == f + k * g) begin ev = 1'b1; ek = k; end
        else if (prof == 2'd1 && k < 3 && j == f + k * g + 1) begin ev = 1'b1; ek = k; end
      end
      chk(beat_valid == ev, tt, beat_valid, ev);
      if (ev && beat_valid) begin
        logic [AW-1:0] c2;
        c2 = {col[AW-1:2], 2'(col[1:0] + 2'(ek))};
        chk(beat_idx == 2'(ek), "R2 index", beat_idx, ek);
        chk(beat_data == word_at(row, c2), "R2 data", beat_data, word_at(row, c2));
      end
      chk(done == (j == tot), flip ? "R7 done" : "R6 done", done, (j == tot));
      if (j == tot) chk(done_cycles == 4'(tot), flip ? "R7 cycles" : "R6 cycles", done_cycles, tot);
      if (j < tot) chk(!req_ready, "R8 busy", req_ready, 0);
    end
    in_burst = 1'b0;
  endtask

  // refresh monitor on the strobes
  bit            r_prev = 1'b0, r_cas = 1'b0, r_inb = 1'b0, wrapped = 1'b0;
  logic [AW-1:0] r_row = '0, exp_ref_row = '0;
  int            r_len = 0, r_rise = 0, last_ref = 0, n_ref = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (dram_ras && !r_prev) begin
        r_row = dram_addr; r_cas = 1'b0; r_len = 0; r_inb = in_burst; r_rise = cyc;
      end
      if (dram_ras) begin
        r_len++;
        if (dram_cas) r_cas = 1'b1;
      end
      if (!dram_ras && r_prev && !r_cas) begin
        chk(r_row == exp_ref_row, "R9 refresh row", r_row, exp_ref_row);
        chk(r_len == RRAS, "R9 refresh length", r_len, RRAS);
        chk(!r_inb, "R10 refresh inside burst", r_inb, 0);
        chk(r_rise - last_ref <= RINT + 20, "R10 refresh spacing", r_rise - last_ref, RINT + 20);
        if (r_row == '0 && n_ref > 0) wrapped = 1'b1;
        last_ref    = r_rise;
        exp_ref_row = exp_ref_row + 1'b1;
        n_ref++;
      end
      r_prev = dram_ras;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20011));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!dram_ras && !dram_cas, "R11 strobes in reset", {dram_ras, dram_cas}, 0);
    chk(!beat_valid && !done, "R11 outputs in reset", {beat_valid, done}, 0);
    chk(req_ready, "R11 ready in reset", req_ready, 1);
    rst = 1'b0;
    // directed corners
    run_burst(11'd0,    11'd0,    2'd0, 1'b0);
    run_burst(11'd2047, 11'd2047, 2'd1, 1'b0);
    run_burst(11'd1234, 11'd2046, 2'd2, 1'b0);
    run_burst(11'd5,    11'd9,    2'd3, 1'b0);
    run_burst(11'd77,   11'd3,    2'd0, 1'b1);
    run_burst(11'd78,   11'd1,    2'd1, 1'b1);
    run_burst(11'd79,   11'd2,    2'd2, 1'b1);
    // random mix
    for (int n = 0; n < 160; n++) begin
      run_burst(11'($urandom), 11'($urandom), 2'($urandom), 1'($urandom));
      repeat ($urandom % 4) @(negedge clk);
    end
    // idle until the refresh row counter has wrapped
    while (n_ref < 2050) @(negedge clk);
    chk(wrapped, "R9 row wrap", wrapped, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule